// File: doc/BRIEF.md
# System Address Interleave Decoder

This block takes a physical address and decides whether it belongs to DRAM and, if it does, which interleave target serves it. It first screens the address against ten fixed reserved windows and against three DRAM ranges. The upper bounds of two of those ranges come from programmable top-of-low and top-of-high registers. It then scans an eight-entry rule table. Each rule covers the span from the previous rule's limit up to its own limit. In the first enabled rule that covers the address, a selectable group of address bits forms an index into an eight-entry target list.

A rule may also ask for a channel override. In that case a modulo-3 or modulo-2 function of a shifted copy of the address is combined with bit 0 of the looked-up target, and the result becomes the output target. Software loads the tables through a write-only register port. A decode request is a one-cycle strobe. The result appears registered on the next cycle as a target byte, a 4-bit failure code and a detail byte.

Top module: `sys_addr_ileave_dec`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `out_valid` is high for exactly that cycle with the result for the sampled `in_addr`. It is low after any edge that samples `in_valid` low.
- R2: Reserved windows are checked first, as index:base/size pairs: 0:0xA0000/128 KiB, 1:0xC0000/256 KiB, 2:0xF00000/1 MiB, 3:0xFE000000/32 MiB, 4:0xFF000000/16 MiB, 5:0xFED20000/384 KiB, 6:0xFED00000/1 MiB, 7:0xFEC00000/1 MiB, 8:0xFEB80000/512 KiB, 9:0xFEB00000/64 KiB. A hit gives code 1, and the detail byte carries the lowest matching index.
- R3: Outside the reserved windows, an address is DRAM if it is at most 0x9FFFF, or lies in [0x100000, low top), or lies in [0x100000000, high top). Any other address gives code 2.
- R4: Rule i covers [limit of rule i-1, limit of rule i), and rule 0 starts at 0. A disabled rule matches nothing but still moves the base for the rule after it. The lowest enabled covering rule wins. With no match the code is 3.
- R5: The mode field selects the index. Mode 0 takes addr[8:6], or {addr[8:7], addr[9]} when the a7 flag is set. Mode 2 takes addr[10:8], mode 3 addr[14:12] and mode 4 addr[32:30]. Modes 5 to 7 give index 0.
- R6: Mode 1 forms the mode-0 index, including the a7 variant, and XORs it with addr[18:16].
- R7: An index not below the rule's target count gives code 4, and the detail byte carries the index.
- R8: When the override is enabled, the address is shifted right by 6, 8 or 12 for shift codes 0, 1 and 2. Shift code 3 gives code 5.
- R9: With a the shifted address and t0 bit 0 of the looked-up target, override type 0 gives ((a mod 3)<<1)|t0. Type 1 gives ((a mod 2)<<1)|t0. Type 2 gives ((a mod 2)<<2)|((~a mod 2)<<1)|t0. Type 3 gives ((a mod 2)<<2)|t0. Types 4 to 7 give code 5.
- R10: The write port decodes `cfg_addr`. If bit 5 is set, bit 0 picks low top (0) or high top (1), both from wdata[45:0]. If bit 5 is clear, bits [4:2] pick the rule and bits [1:0] pick the field. Field 0 is the limit (wdata[45:0]). Field 1 is control: [0] enable, [3:1] mode, [4] a7, [8:5] target count, [9] override enable, [11:10] shift code, [14:12] type. Field 2 holds the targets, with target k at wdata[8k+7:8k]. Field 3 is ignored.
- R11: On success the code is 0, the target is the table entry (or the override channel) and the detail byte is 0. On any failure the target is 0, and the detail byte is 0 except for codes 1 and 4.
- R12: After reset the outputs are zero, every rule is disabled with limit 0, and both tops are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Table write address |
| cfg_wdata | input | 64 | Table write data |
| in_valid | input | 1 | Decode request strobe |
| in_addr | input | 46 | Physical address to decode |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_target | output | 8 | Selected target or override channel |
| out_fail | output | 4 | Failure code, 0 for success |
| out_detail | output | 8 | Window index or offending interleave index |

## Verification
The assertions assume that `in_valid` and `in_addr` are known whenever the block is out of reset. They also assume that no table write lands in the same cycle as a request whose outcome is being checked. The bench respects both conditions: it drives every input on the falling edge and loads the whole table before it issues decode requests. It rewrites a rule only between requests, never during one. The rule limits are programmed in increasing order, so the implicit bases form contiguous spans and every directed address has a single expected owner.

// File: rtl/sad_pkg.sv
package sad_pkg;
  parameter int ADDR_W  = 46;
  parameter int TGT_W   = 8;
  parameter int N_RULES = 8;
  parameter int N_TGTS  = 8;
  parameter int N_WIN   = 10;
  parameter int CFG_DW  = 64;
  localparam int RULE_AW = $clog2(N_RULES);
  localparam int CFG_AW  = RULE_AW + 3;
  localparam int CNT_W   = $clog2(N_TGTS) + 1;
  localparam int IDX_W   = 3;

  typedef enum logic [3:0] {
    FAIL_NONE     = 4'd0,
    FAIL_LEGACY   = 4'd1,
    FAIL_OUTSIDE  = 4'd2,
    FAIL_NO_RULE  = 4'd3,
    FAIL_BAD_IDX  = 4'd4,
    FAIL_BAD_MOD  = 4'd5
  } fail_e;

  typedef struct packed {
    logic [ADDR_W-1:0]                 limit;
    logic                              en;
    logic [2:0]                        mode;
    logic                              a7;
    logic [CNT_W-1:0]                  cnt;
    logic                              mod_en;
    logic [1:0]                        mod_shift;
    logic [2:0]                        mod_type;
    logic [N_TGTS-1:0][TGT_W-1:0]      tgts;
  } rule_t;

  // Reserved window bounds, lower inclusive, upper exclusive.
  function automatic logic [ADDR_W-1:0] win_lo(input int i);
    case (i)
      0: win_lo = ADDR_W'(64'h000A0000);
      1: win_lo = ADDR_W'(64'h000C0000);
      2: win_lo = ADDR_W'(64'h00F00000);
      3: win_lo = ADDR_W'(64'hFE000000);
      4: win_lo = ADDR_W'(64'hFF000000);
      5: win_lo = ADDR_W'(64'hFED20000);
      6: win_lo = ADDR_W'(64'hFED00000);
      7: win_lo = ADDR_W'(64'hFEC00000);
      8: win_lo = ADDR_W'(64'hFEB80000);
      default: win_lo = ADDR_W'(64'hFEB00000);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] win_hi(input int i);
    case (i)
      0: win_hi = win_lo(i) + ADDR_W'(64'h20000);
      1: win_hi = win_lo(i) + ADDR_W'(64'h40000);
      2: win_hi = win_lo(i) + ADDR_W'(64'h100000);
      3: win_hi = win_lo(i) + ADDR_W'(64'h2000000);
      4: win_hi = win_lo(i) + ADDR_W'(64'h1000000);
      5: win_hi = win_lo(i) + ADDR_W'(64'h60000);
      6: win_hi = win_lo(i) + ADDR_W'(64'h100000);
      7: win_hi = win_lo(i) + ADDR_W'(64'h100000);
      8: win_hi = win_lo(i) + ADDR_W'(64'h80000);
      default: win_hi = win_lo(i) + ADDR_W'(64'h10000);
    endcase
  endfunction

  // Interleave index from the selected address bit field.
  function automatic logic [IDX_W-1:0] ileave_idx(input logic [ADDR_W-1:0] a,
                                                  input logic [2:0] mode,
                                                  input logic a7);
    logic [IDX_W-1:0] base6;
    base6 = a7 ? {a[8:7], a[9]} : a[8:6];
    case (mode)
      3'd0:    ileave_idx = base6;
      3'd1:    ileave_idx = base6 ^ a[18:16];
      3'd2:    ileave_idx = a[10:8];
      3'd3:    ileave_idx = a[14:12];
      3'd4:    ileave_idx = a[32:30];
      default: ileave_idx = '0;
    endcase
  endfunction

  // Residue mod 3 by folding 2-bit digits (4 = 1 mod 3), no divider.
  function automatic logic [1:0] mod3_fold(input logic [ADDR_W-1:0] v);
    logic [ADDR_W:0] p;
    logic [1:0] acc;
    logic [1:0] dig;
    logic [2:0] s;
    p = {1'b0, v};
    acc = '0;
    for (int k = 0; k < ADDR_W; k += 2) begin
      dig = p[k +: 2];
      s = {1'b0, acc} + ((dig == 2'd3) ? 3'd0 : {1'b0, dig});
      acc = (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
    end
    mod3_fold = acc;
  endfunction
endpackage

// File: rtl/sad_cfg_file.sv
module sad_cfg_file
  import sad_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [CFG_AW-1:0]            waddr,
  input  logic [CFG_DW-1:0]            wdata,
  output rule_t [N_RULES-1:0]          rules,
  output logic [ADDR_W-1:0]            low_top,
  output logic [ADDR_W-1:0]            high_top
);
  logic [RULE_AW-1:0] rsel;
  assign rsel = waddr[RULE_AW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rules    <= '0;
      low_top  <= '0;
      high_top <= '0;
    end else if (we) begin
      if (waddr[CFG_AW-1]) begin
        if (waddr[0]) high_top <= wdata[ADDR_W-1:0];
        else          low_top  <= wdata[ADDR_W-1:0];
      end else begin
        case (waddr[1:0])
          2'd0: rules[rsel].limit <= wdata[ADDR_W-1:0];
          2'd1: begin
            rules[rsel].en        <= wdata[0];
            rules[rsel].mode      <= wdata[3:1];
            rules[rsel].a7        <= wdata[4];
            rules[rsel].cnt       <= wdata[4+CNT_W:5];
            rules[rsel].mod_en    <= wdata[9];
            rules[rsel].mod_shift <= wdata[11:10];
            rules[rsel].mod_type  <= wdata[14:12];
          end
          2'd2: rules[rsel].tgts <= wdata[N_TGTS*TGT_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sad_window_chk.sv
module sad_window_chk
  import sad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] low_top,
  input  logic [ADDR_W-1:0] high_top,
  output logic              legacy_hit,
  output logic [3:0]        legacy_idx,
  output logic              dram_ok
);
  localparam logic [ADDR_W-1:0] CONV_TOP  = ADDR_W'(64'h9FFFF);
  localparam logic [ADDR_W-1:0] LOW_BASE  = ADDR_W'(64'h100000);
  localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(64'h100000000);

  logic [N_WIN-1:0] hit_vec;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign hit_vec[w] = (addr >= win_lo(w)) && (addr < win_hi(w));
  end

  always_comb begin
    legacy_idx = '0;
    for (int w = N_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) legacy_idx = 4'(w);
    end
  end

  assign legacy_hit = |hit_vec;
  assign dram_ok = (addr <= CONV_TOP)
                 || ((addr >= LOW_BASE)  && (addr < low_top))
                 || ((addr >= HIGH_BASE) && (addr < high_top));
endmodule

// File: rtl/sad_rule_scan.sv
module sad_rule_scan
  import sad_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  rule_t [N_RULES-1:0] rules,
  output logic                rule_hit,
  output rule_t               rule_sel
);
  logic [N_RULES-1:0] cover_vec;

  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    logic [ADDR_W-1:0] lo;
    if (r == 0) begin : g_first
      assign lo = '0;
    end else begin : g_next
      assign lo = rules[r-1].limit;
    end
    assign cover_vec[r] = rules[r].en && (addr >= lo) && (addr < rules[r].limit);
  end

  always_comb begin
    rule_hit = 1'b0;
    rule_sel = '0;
    for (int r = 0; r < N_RULES; r++) begin
      if (!rule_hit && cover_vec[r]) begin
        rule_hit = 1'b1;
        rule_sel = rules[r];
      end
    end
  end
endmodule

// File: rtl/sad_chan_pick.sv
module sad_chan_pick
  import sad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  rule_t             rule,
  output fail_e             fail,
  output logic [TGT_W-1:0]  target,
  output logic [TGT_W-1:0]  detail
);
  logic [IDX_W-1:0]  idx;
  logic [TGT_W-1:0]  raw_tgt;
  logic [ADDR_W-1:0] sh_addr;
  logic              sh_bad;
  logic [1:0]        m3;
  logic              t0;

  assign idx     = ileave_idx(addr, rule.mode, rule.a7);
  assign raw_tgt = rule.tgts[idx];
  assign t0      = raw_tgt[0];

  always_comb begin
    sh_bad = 1'b0;
    case (rule.mod_shift)
      2'd0:    sh_addr = addr >> 6;
      2'd1:    sh_addr = addr >> 8;
      2'd2:    sh_addr = addr >> 12;
      default: begin sh_addr = '0; sh_bad = 1'b1; end
    endcase
  end

  assign m3 = mod3_fold(sh_addr);

  always_comb begin
    fail   = FAIL_NONE;
    target = '0;
    detail = '0;
    if ({1'b0, idx} >= rule.cnt) begin
      fail   = FAIL_BAD_IDX;
      detail = TGT_W'(idx);
    end else if (!rule.mod_en) begin
      target = raw_tgt;
    end else if (sh_bad) begin
      fail = FAIL_BAD_MOD;
    end else begin
      case (rule.mod_type)
        3'd0:    target = TGT_W'({m3, t0});
        3'd1:    target = TGT_W'({1'b0, sh_addr[0], t0});
        3'd2:    target = TGT_W'({sh_addr[0], ~sh_addr[0], t0});
        3'd3:    target = TGT_W'({sh_addr[0], 1'b0, t0});
        default: fail = FAIL_BAD_MOD;
      endcase
    end
  end
endmodule

// File: rtl/sys_addr_ileave_dec.sv
module sys_addr_ileave_dec
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_addr,
  input  logic [63:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [45:0]       in_addr,
  output logic              out_valid,
  output logic [7:0]        out_target,
  output logic [3:0]        out_fail,
  output logic [7:0]        out_detail
);
  rule_t [N_RULES-1:0] rules;
  rule_t               rule_sel;
  logic [ADDR_W-1:0]   low_top, high_top;
  logic                legacy_hit, dram_ok, rule_hit;
  logic [3:0]          legacy_idx;
  fail_e               pick_fail, comb_fail;
  logic [TGT_W-1:0]    pick_tgt, pick_det, comb_tgt, comb_det;

  sad_cfg_file i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .rules(rules), .low_top(low_top), .high_top(high_top)
  );

  sad_window_chk i_win (
    .addr(in_addr), .low_top(low_top), .high_top(high_top),
    .legacy_hit(legacy_hit), .legacy_idx(legacy_idx), .dram_ok(dram_ok)
  );

  sad_rule_scan i_scan (
    .addr(in_addr), .rules(rules), .rule_hit(rule_hit), .rule_sel(rule_sel)
  );

  sad_chan_pick i_pick (
    .addr(in_addr), .rule(rule_sel), .fail(pick_fail),
    .target(pick_tgt), .detail(pick_det)
  );

  always_comb begin
    comb_fail = FAIL_NONE;
    comb_tgt  = '0;
    comb_det  = '0;
    if (legacy_hit) begin
      comb_fail = FAIL_LEGACY;
      comb_det  = TGT_W'(legacy_idx);
    end else if (!dram_ok) begin
      comb_fail = FAIL_OUTSIDE;
    end else if (!rule_hit) begin
      comb_fail = FAIL_NO_RULE;
    end else begin
      comb_fail = pick_fail;
      comb_tgt  = pick_tgt;
      comb_det  = pick_det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_target <= '0;
      out_fail   <= '0;
      out_detail <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_target <= comb_tgt;
        out_fail   <= comb_fail;
        out_detail <= comb_det;
      end
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_legacy_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy_hit) |=> (out_fail == FAIL_LEGACY));
  assert_outside_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_hit && !dram_ok) |=> (out_fail == FAIL_OUTSIDE));
  assert_no_rule_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_hit && dram_ok && !rule_hit) |=> (out_fail == FAIL_NO_RULE));
  assert_fail_target_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fail != 4'd0) |-> (out_target == 8'd0));
  assert_bad_idx_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fail == 4'd4) |-> (out_detail < 8'd8));
endmodule

// File: tb/test_sys_addr_ileave_dec.sv
`timescale 1ns/1ps
module test_sys_addr_ileave_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [45:0] in_addr = '0;
  logic        out_valid;
  logic [7:0]  out_target;
  logic [3:0]  out_fail;
  logic [7:0]  out_detail;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sys_addr_ileave_dec i_sys_addr_ileave_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_target(out_target), .out_fail(out_fail),
    .out_detail(out_detail)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_rule(input int r, input logic [45:0] lim, input bit en,
                          input logic [2:0] mode, input bit a7, input logic [3:0] cnt,
                          input bit men, input logic [1:0] sh, input logic [2:0] ty,
                          input logic [7:0] tbase);
    logic [63:0] tw;
    for (int k = 0; k < 8; k++) tw[k*8 +: 8] = tbase + 8'(k);
    wr({1'b0, 3'(r), 2'd0}, {18'd0, lim});
    wr({1'b0, 3'(r), 2'd1}, {49'd0, ty, sh, men, cnt, a7, mode, en});
    wr({1'b0, 3'(r), 2'd2}, tw);
  endtask

  // Request on one falling edge, registered on the next rising edge,
  // sampled on the following falling edge.
  task automatic dec(input string req, input logic [45:0] a, input logic [3:0] ef,
                     input logic [7:0] et, input logic [7:0] ed);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid", 64'(out_valid), 64'd1);
    check(req, "out_fail", 64'(out_fail), 64'(ef));
    check(req, "out_target", 64'(out_target), 64'(et));
    check(req, "out_detail", 64'(out_detail), 64'(ed));
  endtask

  task automatic t_reset();
    check("R12", "out_valid", 64'(out_valid), 64'd0);
    check("R12", "out_fail", 64'(out_fail), 64'd0);
    check("R12", "out_target", 64'(out_target), 64'd0);
    // R12: empty table, conventional address finds no rule
    dec("R12", 46'h1000, 4'd3, 8'd0, 8'd0);
    @(negedge clk);
    check("R1", "out_valid drop", 64'(out_valid), 64'd0);
  endtask

  task automatic t_program();
    // R10: tops and rule table through the write port
    wr(6'h20, 64'h8000_0000);
    wr(6'h21, 64'h4_0000_0000);
    wr(6'h03, 64'hFFFF);          // field 3 ignored
    set_rule(0, 46'h4000_0000,   1, 3'd0, 0, 4'd8, 0, 2'd0, 3'd0, 8'hA0);
    set_rule(1, 46'h8000_0000,   0, 3'd0, 0, 4'd8, 0, 2'd0, 3'd0, 8'hA0);
    set_rule(2, 46'h2_0000_0000, 1, 3'd1, 1, 4'd8, 0, 2'd0, 3'd0, 8'hB0);
    set_rule(3, 46'h3_0000_0000, 1, 3'd2, 0, 4'd4, 0, 2'd0, 3'd0, 8'hC0);
    set_rule(4, 46'h3_8000_0000, 1, 3'd4, 0, 4'd8, 1, 2'd0, 3'd0, 8'hD0);
    set_rule(5, 46'h3_C000_0000, 1, 3'd3, 0, 4'd8, 1, 2'd1, 3'd2, 8'hE0);
    set_rule(6, 46'h3_E000_0000, 1, 3'd3, 0, 4'd8, 1, 2'd3, 3'd0, 8'hE0);
    set_rule(7, 46'h4_0000_0000, 1, 3'd3, 0, 4'd8, 1, 2'd2, 3'd1, 8'hE0);
  endtask

  task automatic t_legacy();
    dec("R2", 46'hA0000,    4'd1, 8'd0, 8'd0);
    dec("R2", 46'hA1234,    4'd1, 8'd0, 8'd0);
    dec("R2", 46'hFFFFF,    4'd1, 8'd0, 8'd1);
    dec("R2", 46'hF00010,   4'd1, 8'd0, 8'd2);
    dec("R2", 46'hFEC00000, 4'd1, 8'd0, 8'd3); // lowest index wins
  endtask

  task automatic t_ranges();
    dec("R3", 46'h9FFFF,       4'd0, 8'hA7, 8'd0);  // inclusive top
    dec("R3", 46'h8000_0000,   4'd2, 8'd0, 8'd0);   // low top exclusive
    dec("R3", 46'h9000_0000,   4'd2, 8'd0, 8'd0);
    dec("R3", 46'h4_0000_0000, 4'd2, 8'd0, 8'd0);   // high top exclusive
  endtask

  task automatic t_rules();
    dec("R4", 46'h3FFF_FE40,   4'd0, 8'hA1, 8'd0);
    dec("R4", 46'h5000_0000,   4'd3, 8'd0, 8'd0);   // behind disabled rule
    dec("R5", 46'h3FFF_FFC0,   4'd0, 8'hA7, 8'd0);
    dec("R6", 46'h1_0000_0000, 4'd0, 8'hB0, 8'd0);
    dec("R6", 46'h1_0005_0280, 4'd0, 8'hB6, 8'd0);  // a7 variant xor
    dec("R5", 46'h2_0000_0300, 4'd0, 8'hC3, 8'd0);  // addr[10:8]
    dec("R7", 46'h2_0000_0500, 4'd4, 8'd0, 8'd5);
  endtask

  task automatic t_mod();
    dec("R9", 46'h3_0000_0000, 4'd0, 8'd0, 8'd0);   // mod3, addr[32:30]
    dec("R9", 46'h3_0000_0040, 4'd0, 8'd2, 8'd0);
    dec("R9", 46'h3_4000_0080, 4'd0, 8'd1, 8'd0);
    dec("R9", 46'h3_4000_00C0, 4'd0, 8'd3, 8'd0);
    dec("R9", 46'h3_8000_1100, 4'd0, 8'd5, 8'd0);   // type 2, shift 8
    dec("R8", 46'h3_8000_2000, 4'd0, 8'd2, 8'd0);
    dec("R8", 46'h3_C000_0000, 4'd5, 8'd0, 8'd0);   // shift code 3
    dec("R9", 46'h3_E000_3000, 4'd0, 8'd3, 8'd0);   // type 1, shift 12
    dec("R11", 46'h3_E000_2000, 4'd0, 8'd0, 8'd0);
    set_rule(7, 46'h4_0000_0000, 1, 3'd3, 0, 4'd8, 1, 2'd2, 3'd3, 8'hE0);
    dec("R9", 46'h3_E000_3000, 4'd0, 8'd5, 8'd0);   // type 3
    set_rule(7, 46'h4_0000_0000, 1, 3'd3, 0, 4'd8, 1, 2'd2, 3'd5, 8'hE0);
    dec("R9", 46'h3_E000_3000, 4'd5, 8'd0, 8'd0);   // type 5 invalid
    set_rule(7, 46'h4_0000_0000, 1, 3'd3, 0, 4'd8, 0, 2'd2, 3'd5, 8'hE0);
    dec("R10", 46'h3_E000_3000, 4'd0, 8'hE3, 8'd0); // override off
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_legacy();
    t_ranges();
    t_rules();
    t_mod();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule